// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes quotients and remainders for a virtual machine's integer arithmetic, in both a narrow mode (half the register width) and a wide mode (full register width), for unsigned and signed operands. A request is issued with a single-cycle start strobe. The unit then works one quotient bit per clock cycle using a restoring shift-and-subtract loop on operand magnitudes. It fixes the signs of the quotient and the remainder at the end and raises a one-cycle done pulse together with the result.

No exception is raised for a zero divisor. Instead the unit returns a defined value at once, without running the loop. The divisor comes either from a full-width register value or from a 32-bit immediate. The immediate is widened differently in each mode. Signed remainders follow truncated division, so a non-zero remainder always has the sign of the dividend. The most negative dividend divided by minus one wraps and does not trap.

Top module: `idiv_unit`

## Requirements
- R1: With `op_signed`=0 and `op_rem`=0 the result is the unsigned quotient of dividend by divisor, for example 100/7=14 and 0xFFFFFFFFFFFFFFFF/3=0x5555555555555555 in wide mode.
- R2: With `op_signed`=0 and `op_rem`=1 the result is the unsigned remainder, for example 100 mod 7 = 2.
- R3: With `op_signed`=1 and `op_rem`=0 the operands are two's complement and the quotient is truncated toward zero, for example -100/7=-14 and -100/-7=14.
- R4: With `op_signed`=1 and `op_rem`=1 a non-zero remainder has the sign of the dividend: -13 mod 3 = -1 and 13 mod -3 = 1.
- R5: A zero effective divisor gives a quotient result of 0.
- R6: A zero effective divisor with `op_rem`=1 gives the full dividend in wide mode. In narrow mode it gives the low 32 dividend bits with the upper 32 bits zero.
- R7: A zero-divisor request raises done in the cycle right after the start cycle, and busy stays low.
- R8: Any other request holds busy high for exactly 32 cycles (narrow, `mode64`=0) or 64 cycles (wide, `mode64`=1) after the start cycle. Done pulses for one cycle in the cycle after the last busy cycle, and busy is low in that cycle.
- R9: In narrow mode only the low 32 bits of the dividend and divisor are used, and every result has its upper 32 bits zero.
- R10: With `use_imm`=1 the divisor is `imm`. In narrow mode `imm` is used as a 32-bit value. In wide mode it is first sign-extended to 64 bits and then treated as unsigned or signed according to `op_signed`.
- R11: A signed division of the most negative value by -1 returns the dividend as the quotient and 0 as the remainder, in both modes.
- R12: A start strobe while busy is high is ignored: no extra done and no change to the running result.
- R13: After reset, busy, done and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted only while busy is low |
| op_rem | input | 1 | 0 selects the quotient, 1 selects the remainder |
| op_signed | input | 1 | 1 selects two's complement operands |
| mode64 | input | 1 | 1 selects wide mode, 0 selects narrow mode |
| dividend | input | XLEN | Dividend, taken from the destination register |
| divisor | input | XLEN | Register divisor |
| imm | input | XLEN/2 | Immediate divisor |
| use_imm | input | 1 | 1 selects imm as the divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | XLEN | Quotient or remainder |

## Verification
The bench builds the unit with the default XLEN of 64 and drives both modes against it. This brings both loop lengths within reach: the 32-step narrow loop and the 64-step wide loop. It also reaches the most negative 32-bit and 64-bit values for the wrap case, and immediates whose sign bit changes the wide divisor. Narrow cases carry junk in the upper operand bits to show that those bits are dropped. A scoreboard compares every done pulse with the value and latency worked out from the requirements.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    localparam int XLEN_DEF = 64;

    typedef enum logic {
        OP_QUO = 1'b0,
        OP_REM = 1'b1
    } idiv_op_e;

    // Sign and selection flags held for the whole iteration
    typedef struct packed {
        logic     neg_q;
        logic     neg_r;
        idiv_op_e op;
        logic     wide;
    } idiv_ctl_t;

    function automatic int iter_count(input logic wide, input int xlen);
        return wide ? xlen : xlen / 2;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
    parameter int XLEN = 64
) (
    input  logic              mode64,
    input  logic              is_signed,
    input  logic              want_rem,
    input  logic [XLEN-1:0]   a_in,
    input  logic [XLEN-1:0]   b_reg,
    input  logic [XLEN/2-1:0] imm,
    input  logic              use_imm,
    output logic [XLEN-1:0]   mag_a,
    output logic [XLEN-1:0]   mag_b,
    output logic              neg_q,
    output logic              neg_r,
    output logic              b_zero,
    output logic [XLEN-1:0]   zero_res
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] b_src;
    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] b_eff;
    logic            a_neg;
    logic            b_neg;

    always_comb begin
        // Immediate widening depends on the mode
        if (use_imm)
            b_src = mode64 ? {{HALF{imm[HALF-1]}}, imm} : {{HALF{1'b0}}, imm};
        else
            b_src = b_reg;

        // Narrow mode keeps the low half, extended by signedness
        if (mode64) begin
            a_eff = a_in;
            b_eff = b_src;
        end else begin
            a_eff = {{HALF{is_signed & a_in[HALF-1]}}, a_in[HALF-1:0]};
            b_eff = {{HALF{is_signed & b_src[HALF-1]}}, b_src[HALF-1:0]};
        end

        a_neg  = is_signed & a_eff[XLEN-1];
        b_neg  = is_signed & b_eff[XLEN-1];
        mag_a  = a_neg ? (~a_eff + 1'b1) : a_eff;
        mag_b  = b_neg ? (~b_eff + 1'b1) : b_eff;
        neg_q  = a_neg ^ b_neg;
        neg_r  = a_neg;
        b_zero = (b_eff == '0);

        if (!want_rem)
            zero_res = '0;
        else if (mode64)
            zero_res = a_in;
        else
            zero_res = {{HALF{1'b0}}, a_in[HALF-1:0]};
    end

endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            mode64,
    input  logic [XLEN-1:0] mag_a,
    input  logic [XLEN-1:0] mag_b,
    output logic            busy,
    output logic            fin,
    output logic [XLEN-1:0] q_nxt,
    output logic [XLEN-1:0] r_nxt
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);

    logic [XLEN-1:0] q_r;
    logic [XLEN-1:0] r_r;
    logic [XLEN-1:0] d_r;
    logic [CW-1:0]   cnt;
    logic [XLEN:0]   shifted;
    logic [XLEN:0]   diff;
    logic            take;

    // One restoring step: shift in the next dividend bit, try a subtract
    always_comb begin
        shifted = {r_r, q_r[XLEN-1]};
        diff    = shifted - {1'b0, d_r};
        take    = ~diff[XLEN];
        r_nxt   = take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
        q_nxt   = {q_r[XLEN-2:0], take};
        fin     = busy && (cnt == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            // Narrow operands are aligned to the top so the same loop applies
            q_r  <= mode64 ? mag_a : {mag_a[HALF-1:0], {HALF{1'b0}}};
            r_r  <= '0;
            d_r  <= mag_b;
            cnt  <= mode64 ? CW'(XLEN) : CW'(HALF);
            busy <= 1'b1;
        end else if (busy) begin
            q_r <= q_nxt;
            r_r <= r_nxt;
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1))
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/idiv_post.sv
module idiv_post
    import idiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  idiv_ctl_t       ctl,
    input  logic [XLEN-1:0] q_mag,
    input  logic [XLEN-1:0] r_mag,
    output logic [XLEN-1:0] res
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] q_s;
    logic [XLEN-1:0] r_s;
    logic [XLEN-1:0] pick;

    always_comb begin
        q_s  = ctl.neg_q ? (~q_mag + 1'b1) : q_mag;
        r_s  = ctl.neg_r ? (~r_mag + 1'b1) : r_mag;
        pick = (ctl.op == OP_REM) ? r_s : q_s;
        res  = ctl.wide ? pick : {{HALF{1'b0}}, pick[HALF-1:0]};
    end

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_rem,
    input  logic              op_signed,
    input  logic              mode64,
    input  logic [XLEN-1:0]   dividend,
    input  logic [XLEN-1:0]   divisor,
    input  logic [XLEN/2-1:0] imm,
    input  logic              use_imm,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   result
);
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic [XLEN-1:0] zero_res;
    logic [XLEN-1:0] q_nxt;
    logic [XLEN-1:0] r_nxt;
    logic [XLEN-1:0] post_res;
    logic            neg_q;
    logic            neg_r;
    logic            b_zero;
    logic            core_busy;
    logic            fin;
    logic            accept;
    idiv_ctl_t       ctl_q;

    assign accept = start && !core_busy;
    assign busy   = core_busy;

    idiv_prep #(.XLEN(XLEN)) u_prep (
        .mode64    (mode64),
        .is_signed (op_signed),
        .want_rem  (op_rem),
        .a_in      (dividend),
        .b_reg     (divisor),
        .imm       (imm),
        .use_imm   (use_imm),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_q     (neg_q),
        .neg_r     (neg_r),
        .b_zero    (b_zero),
        .zero_res  (zero_res)
    );

    idiv_core #(.XLEN(XLEN)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept && !b_zero),
        .mode64 (mode64),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .busy   (core_busy),
        .fin    (fin),
        .q_nxt  (q_nxt),
        .r_nxt  (r_nxt)
    );

    idiv_post #(.XLEN(XLEN)) u_post (
        .ctl   (ctl_q),
        .q_mag (q_nxt),
        .r_mag (r_nxt),
        .res   (post_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
            ctl_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept && b_zero) begin
                done   <= 1'b1;
                result <= zero_res;
            end else if (accept) begin
                ctl_q <= '{neg_q: neg_q, neg_r: neg_r,
                           op: idiv_op_e'(op_rem), wide: mode64};
            end
            if (fin) begin
                done   <= 1'b1;
                result <= post_res;
            end
        end
    end

endmodule

// File: rtl/idiv_unit_chk.sv
module idiv_unit_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mode64,
    input logic [XLEN-1:0]   divisor,
    input logic [XLEN/2-1:0] imm,
    input logic              use_imm,
    input logic              busy,
    input logic              done,
    input logic [XLEN-1:0]   result
);
    localparam int HALF = XLEN / 2;
    localparam int LW   = $clog2(XLEN + 2);

    logic          zdiv;
    logic          wide_lat;
    logic [LW-1:0] lat;

    assign zdiv = use_imm ? (imm == '0)
                          : (mode64 ? (divisor == '0) : (divisor[HALF-1:0] == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            lat      <= '0;
            wide_lat <= 1'b0;
        end else if (start && !busy) begin
            lat      <= '0;
            wide_lat <= mode64;
        end else if (busy) begin
            lat <= lat + LW'(1);
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R8

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R12

    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8

    AST_LOOP_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (lat == (wide_lat ? LW'(XLEN) : LW'(HALF)))); // R8

    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && zdiv) |=> (done && !busy)); // R7

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (done && !wide_lat) |-> (result[XLEN-1:HALF] == '0)); // R9

    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        done |-> !$isunknown(result)); // R1

endmodule

bind idiv_unit idiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mode64  (mode64),
    .divisor (divisor),
    .imm     (imm),
    .use_imm (use_imm),
    .busy    (busy),
    .done    (done),
    .result  (result)
);

// File: tb/tb_idiv_unit.sv
module tb_idiv_unit;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            op_rem = 1'b0;
    logic            op_signed = 1'b0;
    logic            mode64 = 1'b0;
    logic [63:0]     dividend = '0;
    logic [63:0]     divisor = '0;
    logic [31:0]     imm = '0;
    logic            use_imm = 1'b0;
    logic            busy;
    logic            done;
    logic [63:0]     result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [63:0] exp;
        int          lat;
        int          t0;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idiv_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst(rst), .start(start), .op_rem(op_rem),
        .op_signed(op_signed), .mode64(mode64), .dividend(dividend),
        .divisor(divisor), .imm(imm), .use_imm(use_imm),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [63:0] ref_model(bit rem, bit sgn, bit w,
                                              logic [63:0] a, logic [63:0] b);
        logic signed [31:0] sa32, sb32;
        logic signed [63:0] sa64, sb64;
        if (!w) begin
            sa32 = a[31:0];
            sb32 = b[31:0];
            if (sb32 == 0) return rem ? {32'h0, a[31:0]} : 64'h0;
            if (sgn) begin
                if (sa32 == 32'sh80000000 && sb32 == -32'sd1)
                    return rem ? 64'h0 : {32'h0, a[31:0]};
                return rem ? {32'h0, 32'(sa32 % sb32)} : {32'h0, 32'(sa32 / sb32)};
            end
            return rem ? {32'h0, a[31:0] % b[31:0]} : {32'h0, a[31:0] / b[31:0]};
        end
        sa64 = a;
        sb64 = b;
        if (b == 0) return rem ? a : 64'h0;
        if (sgn) begin
            if (a == 64'h8000000000000000 && sb64 == -64'sd1)
                return rem ? 64'h0 : a;
            return rem ? 64'(sa64 % sb64) : 64'(sa64 / sb64);
        end
        return rem ? a % b : a / b;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    // Driver: issue one request and push its expected outcome
    task automatic issue(string tag, bit rem, bit sgn, bit w, logic [63:0] a,
                         logic [63:0] breg, logic [31:0] k, bit ui);
        logic [63:0] beff;
        sb_item_t it;
        beff = ui ? (w ? {{32{k[31]}}, k} : {32'h0, k}) : breg;
        it.exp = ref_model(rem, sgn, w, a, beff);
        it.lat = (w ? (beff == 0) : (beff[31:0] == 0)) ? 1 : (w ? 65 : 33);
        it.tag = tag;
        @(negedge clk);
        op_rem = rem; op_signed = sgn; mode64 = w; dividend = a;
        divisor = breg; imm = k; use_imm = ui; start = 1'b1;
        it.t0 = cyc;
        sb.push_back(it);
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(string tag, bit rem, bit sgn, bit w, logic [63:0] a,
                       logic [63:0] breg, logic [31:0] k, bit ui);
        issue(tag, rem, sgn, w, a, breg, k, ui);
        drain();
    endtask

    // Monitor: compare each done pulse with the scoreboard front
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12: actual unexpected done expected none");
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                check(it.tag, result, it.exp);
                check({it.tag, " latency"}, 64'(cyc - it.t0), 64'(it.lat));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R13 busy", 64'(busy), 64'h0);
        check("R13 done", 64'(done), 64'h0);
        check("R13 result", result, 64'h0);

        run("R1 small", 0, 0, 1, 64'd100, 64'd7, 32'h0, 0);
        run("R1 wide", 0, 0, 1, 64'hFFFFFFFFFFFFFFFF, 64'd3, 32'h0, 0);
        run("R1 narrow", 0, 0, 0, 64'd1000, 64'd9, 32'h0, 0);
        run("R2 small", 1, 0, 1, 64'd100, 64'd7, 32'h0, 0);
        run("R2 msb", 1, 0, 1, 64'hF000000000000123, 64'h0000000100000001, 32'h0, 0);
        run("R3 neg by pos", 0, 1, 1, -64'sd100, 64'd7, 32'h0, 0);
        run("R3 pos by neg", 0, 1, 1, 64'd100, -64'sd7, 32'h0, 0);
        run("R3 both neg narrow", 0, 1, 0, {32'hDEAD0000, 32'hFFFFFF9C}, {32'h0, 32'hFFFFFFF9}, 32'h0, 0);
        run("R4 -13 mod 3", 1, 1, 1, -64'sd13, 64'd3, 32'h0, 0);
        run("R4 13 mod -3", 1, 1, 1, 64'd13, -64'sd3, 32'h0, 0);
        run("R4 narrow -13 mod 3", 1, 1, 0, {32'h0, 32'hFFFFFFF3}, 64'd3, 32'h0, 0);
        run("R5 wide quo", 0, 1, 1, 64'd55, 64'd0, 32'h0, 0);
        run("R5 narrow quo", 0, 0, 0, 64'd55, 64'hABCD000000000000, 32'h0, 0);
        run("R6 R7 wide rem", 1, 0, 1, 64'hCAFEF00D12345678, 64'd0, 32'h0, 0);
        run("R6 R7 narrow rem", 1, 1, 0, 64'hCAFEF00D12345678, 64'h0, 32'h0, 1);
        run("R8 R9 narrow junk", 0, 0, 0, 64'h5555555500000064, 64'hAAAAAAAA0000000A, 32'h0, 0);
        run("R9 narrow rem junk", 1, 0, 0, 64'hFFFFFFFF80000001, 64'hFFFFFFFF00000010, 32'h0, 0);
        run("R10 wide imm sext", 0, 0, 1, 64'hFFFFFFFFFFFFFFFF, 64'd5, 32'hFFFFFFFE, 1);
        run("R10 narrow imm unsigned", 0, 0, 0, 64'hFFFFFFFF, 64'd5, 32'hFFFFFFFE, 1);
        run("R10 narrow imm signed", 0, 1, 0, 64'd10, 64'd5, 32'hFFFFFFFE, 1);
        run("R10 wide imm signed", 0, 1, 1, -64'sd20, 64'd0, 32'hFFFFFFFB, 1);
        run("R11 wide quo", 0, 1, 1, 64'h8000000000000000, -64'sd1, 32'h0, 0);
        run("R11 wide rem", 1, 1, 1, 64'h8000000000000000, -64'sd1, 32'h0, 0);
        run("R11 narrow quo", 0, 1, 0, 64'h80000000, 64'h0, 32'hFFFFFFFF, 1);
        run("R11 narrow rem", 1, 1, 0, 64'h80000000, 64'hFFFFFFFF, 32'h0, 0);

        // R12: strobes while busy must not start anything
        issue("R12 running op", 0, 0, 1, 64'd12345, 64'd11, 32'h0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R12 busy held", 64'(busy), 64'h1);
            dividend = 64'd999; divisor = 64'd0; use_imm = 1'b0; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (5) @(negedge clk);
        check("R12 idle after", 64'(busy), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule